// File: doc/BRIEF.md
# Burst-Aware Slave Arbiter

This block decides which of N bus masters owns one slave port of a multi-master AHB-style interconnect. One copy sits in front of each slave, so each slave can be set up differently. Every cycle it takes the request lines of all masters and the transfer type, burst type and ready signal of the master that is granted now. It drives a registered grant that is one-hot, or all zero when no master owns the port.

The grant moves only at safe cycles. These are: the port is idle, a single transfer completes, the last beat of a fixed-length burst completes, a programmable boundary inside an undefined-length INCR burst is reached, or a slot counter of accepted beats reaches its limit. At such a cycle the winner is picked by round-robin or by fixed priority. If nobody is requesting, a default-master policy decides the grant. The beat and slot counting is done inside the block. Configuration arrives on static input ports that are expected to change only while reset is asserted.

Top module: `ahb_slave_arb`

## Requirements
- R1: While `rst` is high at a clock edge, `grant` becomes all zero. The round-robin search after reset starts at master 0.
- R2: `grant` is one-hot or zero. It changes only at the edge that ends a safe cycle (R6 to R10). A cycle with `htrans` = 2'b01 (busy) is never safe.
- R3: With `cfg_fixed_prio` = 0 (round-robin), the winner is the first requesting master, searching upward with wrap-around from the index after the last master that was granted.
- R4: With `cfg_fixed_prio` = 1, the requesting master with the largest value in `cfg_prio[i*PW +: PW]` wins. Among equal values, the lowest index wins.
- R5: At a safe cycle with no requests, `cfg_def_mode` decides the grant. 0 releases it to all zero. 1 keeps the current grant. 2 grants master `cfg_def_mst`.
- R6: A cycle is safe when `grant` is zero or `htrans` = 2'b00 (idle).
- R7: A cycle is safe when an accepted beat (`htrans` 2'b10 or 2'b11 with `hready` high) carries `hburst` = 3'b000 (single).
- R8: For `hburst` 3'b010/3'b011, 3'b100/3'b101 and 3'b110/3'b111, the accepted beat number 4, 8 or 16 of the burst is safe. `htrans` 2'b10 starts the count at 1.
- R9: For `hburst` = 3'b001 (INCR), `cfg_incr_break` 0 never makes a beat safe. The values 1, 2 and 3 make safe each accepted beat whose number is a multiple of 4, 8 or 16.
- R10: A nonzero `cfg_slot_limit` makes safe any accepted beat at which the count of accepted beats since the last grant change reaches or exceeds the limit. A limit of 0 disables this rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Request line of each master |
| htrans | input | 2 | Transfer type of the granted master (00 idle, 01 busy, 10 nonseq, 11 seq) |
| hburst | input | 3 | Burst type of the granted master |
| hready | input | 1 | High when the current beat is accepted by the slave |
| cfg_fixed_prio | input | 1 | 0 round-robin, 1 fixed priority |
| cfg_def_mode | input | 2 | Default-master policy (0 none, 1 keep last, 2 fixed) |
| cfg_def_mst | input | IW | Master granted in fixed-default policy |
| cfg_prio | input | N*PW | Priority value of each master, packed by index |
| cfg_slot_limit | input | SLOT_W | Beat limit of one tenure, 0 disables |
| cfg_incr_break | input | 2 | INCR break boundary (0 none, 1 four, 2 eight, 3 sixteen) |
| grant | output | N | Registered one-hot grant |

## Verification
A beat counter that is off by one shows up as a grant that moves one beat early or late against a burst end or an INCR boundary. This becomes visible on `grant` one cycle after the beat in question. A wrong round-robin pointer or slot count gives a different winner, or a held grant, at the next safe cycle. In a sweep where requests change every cycle, that cycle comes within a few clocks. The bench models the grant from the requirements for every configuration. It compares the grant every cycle, so a divergence is caught at the first cycle where the two grants differ.

// File: rtl/ahb_arb_pkg.sv
package ahb_arb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;

  typedef enum logic [1:0] {
    DEF_NONE  = 2'b00,
    DEF_LAST  = 2'b01,
    DEF_FIXED = 2'b10
  } def_mode_e;

  // beats in a fixed-length burst, 0 when the length is not fixed
  function automatic logic [4:0] burst_beats(input logic [2:0] hb);
    case (hb)
      3'b010, 3'b011: burst_beats = 5'd4;
      3'b100, 3'b101: burst_beats = 5'd8;
      3'b110, 3'b111: burst_beats = 5'd16;
      default:        burst_beats = 5'd0;
    endcase
  endfunction

endpackage

// File: rtl/arb_safe_point.sv
module arb_safe_point
  import ahb_arb_pkg::*;
#(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              owned,
  input  logic              grant_chg,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  input  logic [1:0]        cfg_incr_break,
  input  logic [SLOT_W-1:0] cfg_slot_limit,
  output logic              safe
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

  logic [4:0]        beat_q;
  logic [SLOT_W-1:0] slot_q;
  logic              accepted;
  logic [4:0]        beat_now;
  logic [4:0]        fixed_len;
  logic [SLOT_W-1:0] slot_now;
  logic              is_idle, single_end, fixed_end, incr_end, slot_hit;

  assign accepted  = owned && htrans[1] && hready;
  assign beat_now  = (htrans == TR_NONSEQ) ? 5'd1 : beat_q + 5'd1;
  assign fixed_len = burst_beats(hburst);
  assign slot_now  = (slot_q == SLOT_MAX) ? slot_q : slot_q + 1'b1;

  assign is_idle    = !owned || (htrans == TR_IDLE);
  assign single_end = accepted && (hburst == BU_SINGLE);
  assign fixed_end  = accepted && (fixed_len != 5'd0) && (beat_now == fixed_len);
  assign slot_hit   = accepted && (cfg_slot_limit != '0) && (slot_now >= cfg_slot_limit);

  always_comb begin
    incr_end = 1'b0;
    if (accepted && hburst == BU_INCR) begin
      case (cfg_incr_break)
        2'd1:    incr_end = (beat_now[1:0] == 2'd0);
        2'd2:    incr_end = (beat_now[2:0] == 3'd0);
        2'd3:    incr_end = (beat_now[3:0] == 4'd0);
        default: incr_end = 1'b0;
      endcase
    end
  end

  assign safe = is_idle || single_end || fixed_end || incr_end || slot_hit;

  always_ff @(posedge clk) begin
    if (rst || grant_chg) begin
      beat_q <= '0;
      slot_q <= '0;
    end else if (accepted) begin
      beat_q <= beat_now;
      slot_q <= slot_now;
    end
  end

endmodule

// File: rtl/arb_select.sv
module arb_select #(
  parameter int N  = 4,
  parameter int PW = 2,
  parameter int IW = 2
) (
  input  logic [N-1:0]    req,
  input  logic            cfg_fixed_prio,
  input  logic [N*PW-1:0] cfg_prio,
  input  logic [IW-1:0]   last_idx,
  output logic            win_valid,
  output logic [IW-1:0]   win_idx
);

  logic [PW-1:0] prio [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_unpack
      assign prio[g] = cfg_prio[g*PW +: PW];
    end
  endgenerate

  logic          rr_found;
  logic [IW-1:0] rr_idx;
  logic          fp_found;
  logic [IW-1:0] fp_idx;
  logic [PW-1:0] fp_best;

  // round-robin: first requester after the last winner
  always_comb begin
    rr_found = 1'b0;
    rr_idx   = '0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = int'(last_idx) + k;
      if (cand >= N) cand = cand - N;
      if (!rr_found && req[cand]) begin
        rr_found = 1'b1;
        rr_idx   = IW'(cand);
      end
    end
  end

  // fixed priority: strictly larger value replaces, so ties keep the lower index
  always_comb begin
    fp_found = 1'b0;
    fp_idx   = '0;
    fp_best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!fp_found || prio[i] > fp_best)) begin
        fp_found = 1'b1;
        fp_idx   = IW'(i);
        fp_best  = prio[i];
      end
    end
  end

  assign win_valid = cfg_fixed_prio ? fp_found : rr_found;
  assign win_idx   = cfg_fixed_prio ? fp_idx   : rr_idx;

endmodule

// File: rtl/ahb_slave_arb.sv
module ahb_slave_arb
  import ahb_arb_pkg::*;
#(
  parameter int N      = 4,
  parameter int PW     = 2,
  parameter int SLOT_W = 8,
  localparam int IW    = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      req,
  input  logic [1:0]        htrans,
  input  logic [2:0]        hburst,
  input  logic              hready,
  input  logic              cfg_fixed_prio,
  input  logic [1:0]        cfg_def_mode,
  input  logic [IW-1:0]     cfg_def_mst,
  input  logic [N*PW-1:0]   cfg_prio,
  input  logic [SLOT_W-1:0] cfg_slot_limit,
  input  logic [1:0]        cfg_incr_break,
  output logic [N-1:0]      grant
);

  localparam logic [IW-1:0] LAST_RST = IW'(N - 1);

  logic [N-1:0]  grant_q;
  logic [N-1:0]  grant_nxt;
  logic [IW-1:0] last_q;
  logic          safe;
  logic          win_valid;
  logic [IW-1:0] win_idx;
  logic          grant_chg;

  arb_safe_point #(.SLOT_W(SLOT_W)) u_safe (
    .clk            (clk),
    .rst            (rst),
    .owned          (|grant_q),
    .grant_chg      (grant_chg),
    .htrans         (htrans),
    .hburst         (hburst),
    .hready         (hready),
    .cfg_incr_break (cfg_incr_break),
    .cfg_slot_limit (cfg_slot_limit),
    .safe           (safe)
  );

  arb_select #(.N(N), .PW(PW), .IW(IW)) u_sel (
    .req            (req),
    .cfg_fixed_prio (cfg_fixed_prio),
    .cfg_prio       (cfg_prio),
    .last_idx       (last_q),
    .win_valid      (win_valid),
    .win_idx        (win_idx)
  );

  always_comb begin
    grant_nxt = grant_q;
    if (safe) begin
      if (win_valid) begin
        grant_nxt = '0;
        grant_nxt[win_idx] = 1'b1;
      end else begin
        case (cfg_def_mode)
          DEF_NONE:  grant_nxt = '0;
          DEF_FIXED: begin
            grant_nxt = '0;
            grant_nxt[cfg_def_mst] = 1'b1;
          end
          default:   grant_nxt = grant_q;
        endcase
      end
    end
  end

  assign grant_chg = (grant_nxt != grant_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= LAST_RST;
    end else begin
      grant_q <= grant_nxt;
      if (safe && win_valid) last_q <= win_idx;
      else if (grant_chg && cfg_def_mode == DEF_FIXED) last_q <= cfg_def_mst;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/ahb_slave_arb_chk.sv
module ahb_slave_arb_chk #(
  parameter int N      = 4,
  parameter int PW     = 2,
  parameter int SLOT_W = 8,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      req,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic              hready,
  input logic [1:0]        cfg_def_mode,
  input logic [IW-1:0]     cfg_def_mst,
  input logic [SLOT_W-1:0] cfg_slot_limit,
  input logic [1:0]        cfg_incr_break,
  input logic [N-1:0]      grant
);

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> grant == '0); // R1

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R2

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && htrans == 2'b01) |=> $stable(grant)); // R2

  AST_NO_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (cfg_def_mode == 2'd0 && req == '0 && grant == '0) |=> grant == '0); // R5

  AST_FIXED_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (cfg_def_mode == 2'd2 && req == '0 && grant == '0) |=> grant == (N'(1) << $past(cfg_def_mst))); // R5

  AST_SINGLE_REARB: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && htrans[1] && hready && hburst == 3'b000 && $countones(req) == 1)
    |=> grant == $past(req)); // R7

  AST_INCR_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
    (grant != '0 && htrans == 2'b11 && hburst == 3'b001 && cfg_incr_break == 2'd0 && cfg_slot_limit == '0)
    |=> $stable(grant)); // R9

endmodule

bind ahb_slave_arb ahb_slave_arb_chk #(.N(N), .PW(PW), .SLOT_W(SLOT_W), .IW(IW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .req            (req),
  .htrans         (htrans),
  .hburst         (hburst),
  .hready         (hready),
  .cfg_def_mode   (cfg_def_mode),
  .cfg_def_mst    (cfg_def_mst),
  .cfg_slot_limit (cfg_slot_limit),
  .cfg_incr_break (cfg_incr_break),
  .grant          (grant)
);

// File: tb/ahb_slave_arb_test.sv
`timescale 1ns/1ps
module ahb_slave_arb_test;

  localparam int N  = 4;
  localparam int PW = 2;
  localparam int SW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req = '0;
  logic [1:0]    htrans = 2'b00;
  logic [2:0]    hburst = 3'b000;
  logic          hready = 1'b0;
  logic          cfg_fixed_prio = 1'b0;
  logic [1:0]    cfg_def_mode = 2'd0;
  logic [IW-1:0] cfg_def_mst = '0;
  logic [N*PW-1:0] cfg_prio = {2'd0, 2'd3, 2'd3, 2'd1};
  logic [SW-1:0] cfg_slot_limit = '0;
  logic [1:0]    cfg_incr_break = 2'd0;
  logic [N-1:0]  grant;

  ahb_slave_arb #(.N(N), .PW(PW), .SLOT_W(SW)) uut (
    .clk(clk), .rst(rst), .req(req), .htrans(htrans), .hburst(hburst), .hready(hready),
    .cfg_fixed_prio(cfg_fixed_prio), .cfg_def_mode(cfg_def_mode), .cfg_def_mst(cfg_def_mst),
    .cfg_prio(cfg_prio), .cfg_slot_limit(cfg_slot_limit), .cfg_incr_break(cfg_incr_break),
    .grant(grant)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // reference state
  logic [N-1:0] m_grant = '0;
  int m_last = N - 1;
  int m_beat = 0;
  int m_slot = 0;
  string why = "R1";
  // bench master sequencer
  bit   s_active = 0;
  int   s_beats = 0;
  logic [2:0] s_burst = 3'b000;
  logic [31:0] lf = 32'h1ACE_B00C;

  function automatic int blen(input logic [2:0] hb);
    case (hb)
      3'b000: return 1;
      3'b001: return 40;
      3'b010, 3'b011: return 4;
      3'b100, 3'b101: return 8;
      default: return 16;
    endcase
  endfunction

  // requirement model, evaluated at each edge
  always @(posedge clk) begin
    if (rst) begin
      m_grant = '0; m_last = N - 1; m_beat = 0; m_slot = 0; s_active = 0; s_beats = 0;
    end else begin
      bit acc, safe;
      int bnow, lim, brk, best;
      logic [N-1:0] nxt;
      acc  = (m_grant != '0) && htrans[1] && hready;
      bnow = (htrans == 2'b10) ? 1 : m_beat + 1;
      lim  = int'(cfg_slot_limit);
      brk  = (cfg_incr_break == 0) ? 0 : (2 << cfg_incr_break);
      safe = 1'b1;
      if (m_grant == '0 || htrans == 2'b00) why = "R6";
      else if (acc && hburst == 3'b000) why = "R7";
      else if (acc && hburst >= 3'b010 && bnow == blen(hburst)) why = "R8";
      else if (acc && hburst == 3'b001 && brk != 0 && (bnow % brk) == 0) why = "R9";
      else if (acc && lim != 0 && m_slot + 1 >= lim) why = "R10";
      else begin safe = 1'b0; why = "R2"; end
      nxt = m_grant;
      if (safe) begin
        best = -1;
        if (cfg_fixed_prio) begin
          for (int i = 0; i < N; i++)
            if (req[i] && (best < 0 || cfg_prio[i*PW +: PW] > cfg_prio[best*PW +: PW])) best = i;
        end else begin
          for (int k = 1; k <= N; k++)
            if (best < 0 && req[(m_last + k) % N]) best = (m_last + k) % N;
        end
        if (best >= 0) begin
          nxt = '0; nxt[best] = 1'b1; m_last = best;
          why = {why, cfg_fixed_prio ? "/R4" : "/R3"};
        end else begin
          why = {why, "/R5"};
          if (cfg_def_mode == 2'd0) nxt = '0;
          else if (cfg_def_mode == 2'd2) begin
            nxt = '0; nxt[cfg_def_mst] = 1'b1;
            if (nxt != m_grant) m_last = int'(cfg_def_mst);
          end
        end
      end
      // sequencer bookkeeping
      if (acc) begin
        if (htrans == 2'b10) begin s_active = 1; s_beats = 1; end
        else s_beats++;
        if (s_beats >= blen(s_burst)) s_active = 0;
      end
      if (nxt != m_grant) begin
        m_beat = 0; m_slot = 0; s_active = 0;
      end else if (acc) begin
        m_beat = bnow;
        m_slot = (m_slot < 255) ? m_slot + 1 : 255;
      end
      m_grant = nxt;
    end
  end

  task automatic check_grant(input string tag);
    compared++;
    if (grant !== m_grant) begin
      mismatched++;
      $display("FAIL %s: grant=%b expected=%b", tag, grant, m_grant);
    end
  endtask

  task automatic drive_cycle();
    lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
    req    = lf[3:0] & lf[7:4];
    hready = |lf[9:8];
    if (m_grant == '0) begin
      htrans = 2'b00;
    end else if (!s_active) begin
      if (lf[11:10] == 2'b00) htrans = 2'b00;
      else begin
        htrans  = 2'b10;
        s_burst = lf[14:12];
        hburst  = s_burst;
      end
    end else begin
      htrans = (lf[17:15] == 3'b000) ? 2'b01 : 2'b11;
      hburst = s_burst;
    end
  endtask

  initial begin : main
    int slims[3];
    slims = '{0, 3, 7};
    for (int fx = 0; fx < 2; fx++)
      for (int dm = 0; dm < 3; dm++)
        for (int ib = 0; ib < 4; ib++)
          for (int sl = 0; sl < 3; sl++) begin
            @(negedge clk);
            rst = 1'b1;
            req = '0; htrans = 2'b00; hready = 1'b0;
            cfg_fixed_prio = fx[0];
            cfg_def_mode   = dm[1:0];
            cfg_def_mst    = IW'(ib + sl);
            cfg_incr_break = ib[1:0];
            cfg_slot_limit = SW'(slims[sl]);
            repeat (2) @(negedge clk);
            check_grant("R1 reset"); // R1: grant cleared
            rst = 1'b0;
            for (int c = 0; c < 250; c++) begin
              drive_cycle();
              @(negedge clk);
              // R2..R10: every cycle compared against the requirement model
              check_grant(why);
            end
          end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : watchdog
    #1_000_000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule